// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple synchronous request port and an asynchronous 1M x 16 EDO DRAM. A host hands it one read or write at a time through a valid/ready handshake: a 20-bit word address, a 2-bit byte enable and, for writes, 16 bits of data. The controller splits the address into a row half and a column half on a shared 10-bit bus. It sequences the row strobe, the per-byte column strobes, the write enable and the output enable, and for reads it returns the captured data with a one-cycle response pulse. All strobe widths are parameters counted in clock cycles.

A free-running pacer raises a refresh request about every 15.6 us, derived from the clock frequency parameter, so that 1024 refreshes fit in 16 ms. Each refresh is CAS-before-RAS: every column strobe goes low first, then the row strobe falls, and the DRAM supplies the row itself. A pending refresh wins over a new host request when the sequencer is idle. It never breaks into an access that has already started.

The sequencer has six states. SEQ_IDLE goes to SEQ_REF_SETUP when a refresh is pending, otherwise to SEQ_ROW when a request is valid. SEQ_ROW goes to SEQ_COL after T_RCD cycles. SEQ_COL goes to SEQ_PRECHG after T_CAS cycles. SEQ_REF_SETUP goes to SEQ_REF_HOLD after T_CSR cycles. SEQ_REF_HOLD goes to SEQ_PRECHG after T_REF cycles. SEQ_PRECHG returns to SEQ_IDLE after T_RP cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive), no lane is driven, rsp_valid is low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is low whenever the row strobe is low, and every accepted request produces exactly one access cycle.
- R3: While the row strobe is low and the column strobes are still high, mem_addr carries req_addr[19:10]. While the column strobes are low, it carries req_addr[9:0].
- R4: In an access, the row strobe is low for exactly T_RCD cycles before the column strobes fall. The column strobes stay low for exactly T_CAS cycles, and the row and column strobes rise in the same cycle. The row strobe then stays high for at least T_RP cycles before it falls again.
- R5: req_be bit 0 selects the lower lane (mem_cas_n[0], data bits 7:0) and bit 1 selects the upper lane (mem_cas_n[1], data bits 15:8). An unselected lane's column strobe stays high and that lane is never driven.
- R6: A write is an early write. Write enable is low from the cycle the row strobe falls until the cycle ends, and so it is low before any column strobe falls. While the column strobes are low, the selected lanes drive req_wdata and output enable stays high.
- R7: A read keeps write enable high and pulls output enable low during the column phase. Data is sampled on the last column-low cycle and returned on rsp_rdata with rsp_valid high for exactly one cycle, the cycle after. Unselected lanes read as zero.
- R8: A refresh request is raised every REF_TICKS = CLK_KHZ*156/10000 cycles. Successive refreshes are spaced REF_TICKS apart, give or take one access cycle.
- R9: In a refresh, all column strobes are low for at least T_CSR cycles while the row strobe is high. The row strobe is then low for exactly T_REF cycles with the column strobes still low, and then all strobes rise together. Output enable stays high and no lane is driven.
- R10: When idle with a refresh pending, the refresh starts before any waiting host request, so a continuous stream of requests cannot hold off refresh.
- R11: Whenever the row strobe is high, output enable is high and no data lane is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_be | input | 2 | Byte enable: bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 10 | Multiplexed DRAM address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 2 | Column strobes, bit 0 lower lane, bit 1 upper lane |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data toward the DRAM |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the DRAM |

## Verification
The assertions assume that the host holds a request's fields stable while req_valid is high and req_ready is low. They also assume that the timing parameters are at least one cycle. The bench drives requests only at the falling clock edge and keeps them unchanged until the edge that takes them. A small DRAM model in the bench returns a marker byte on any lane whose strobe is high, so a missing lane mask shows up in the returned data. The bench uses row and column values below 64, so the model's small array never aliases two addresses that the bench uses.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ROW,
        SEQ_COL,
        SEQ_PRECHG,
        SEQ_REF_SETUP,
        SEQ_REF_HOLD
    } seq_state_e;

endpackage

// File: rtl/edo_refresh_pacer.sv
module edo_refresh_pacer #(
    parameter int REF_TICKS = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);

    localparam int TW = (REF_TICKS > 2) ? $clog2(REF_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_TICKS - 1);

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pend <= 1'b0;
        end else if (tick) begin
            ref_pend <= 1'b1;
        end else if (ref_ack) begin
            ref_pend <= 1'b0;
        end
    end

    // R8: a raised request stays up until the sequencer takes it
    a_r8_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !ref_ack) |=> ref_pend);

    // R8: a request only appears on a pacer tick
    a_r8_pend_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_pend) |-> $past(tick));

endmodule

// File: rtl/edo_seq_fsm.sv
module edo_seq_fsm
    import edo_ctrl_pkg::*;
#(
    parameter int LANES = 2,
    parameter int T_RCD = 2,
    parameter int T_CAS = 2,
    parameter int T_RP  = 2,
    parameter int T_CSR = 1,
    parameter int T_REF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             ref_pend,
    input  logic [LANES-1:0] lat_be,
    input  logic             lat_wr,
    output logic             req_ready,
    output logic             accept,
    output logic             ref_ack,
    output logic             sel_row,
    output logic             sel_col,
    output logic             wr_drive,
    output logic             sample,
    output logic             ras_n,
    output logic [LANES-1:0] cas_n,
    output logic             we_n,
    output logic             oe_n
);

    localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int M2   = (T_RP > T_CSR) ? T_RP : T_CSR;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXD = (M3 > T_REF) ? M3 : T_REF;
    localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_CAS = CW'(T_CAS - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_REF = CW'(T_REF - 1);

    seq_state_e    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          cnt_done;

    assign cnt_done = (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state and phase counter
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt_done ? '0 : cnt - 1'b1;
        unique case (state)
            SEQ_IDLE: begin
                if (ref_pend) begin
                    nxt     = SEQ_REF_SETUP;
                    cnt_nxt = L_CSR;
                end else if (req_valid) begin
                    nxt     = SEQ_ROW;
                    cnt_nxt = L_RCD;
                end
            end
            SEQ_ROW: begin
                if (cnt_done) begin
                    nxt     = SEQ_COL;
                    cnt_nxt = L_CAS;
                end
            end
            SEQ_COL: begin
                if (cnt_done) begin
                    nxt     = SEQ_PRECHG;
                    cnt_nxt = L_RP;
                end
            end
            SEQ_PRECHG: begin
                if (cnt_done) begin
                    nxt = SEQ_IDLE;
                end
            end
            SEQ_REF_SETUP: begin
                if (cnt_done) begin
                    nxt     = SEQ_REF_HOLD;
                    cnt_nxt = L_REF;
                end
            end
            SEQ_REF_HOLD: begin
                if (cnt_done) begin
                    nxt     = SEQ_PRECHG;
                    cnt_nxt = L_RP;
                end
            end
            default: begin
                nxt     = SEQ_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == SEQ_IDLE) && !ref_pend;
        accept    = req_ready && req_valid;
        ref_ack   = (state == SEQ_IDLE) && ref_pend;
        sel_row   = (state == SEQ_ROW);
        sel_col   = (state == SEQ_COL);
        wr_drive  = (state == SEQ_COL) && lat_wr;
        sample    = (state == SEQ_COL) && cnt_done && !lat_wr;
        ras_n     = !((state == SEQ_ROW) || (state == SEQ_COL) || (state == SEQ_REF_HOLD));
        we_n      = !(((state == SEQ_ROW) || (state == SEQ_COL)) && lat_wr);
        oe_n      = !((state == SEQ_COL) && !lat_wr);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_cas
        assign cas_n[g] = !(((state == SEQ_COL) && lat_be[g])
                            || (state == SEQ_REF_SETUP)
                            || (state == SEQ_REF_HOLD));
    end

    // R2: the host is only offered the port with all strobes parked high
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && (cas_n == '1)));

    // R6: a column strobe falling in a write cycle finds write enable already low
    a_r6_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !we_n && (cas_n != '1) && $past(cas_n == '1)) |-> $past(!we_n));

    // R7: output enable is never asserted together with write enable
    a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n);

    // R9: a row strobe fall with column strobes low was preceded by those strobes low
    a_r9_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (cas_n != '1)) |-> $past(cas_n != '1));

    // R10: a pending refresh is never passed over by a host request
    a_r10_ref_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && ref_pend) |=> (state == SEQ_REF_SETUP));

endmodule

// File: rtl/edo_datapath.sv
module edo_datapath #(
    parameter int ROW_BITS  = 10,
    parameter int COL_BITS  = 10,
    parameter int LANES     = 2,
    parameter int LANE_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          req_write,
    input  logic [ROW_BITS+COL_BITS-1:0]  req_addr,
    input  logic [LANES-1:0]              req_be,
    input  logic [LANES*LANE_BITS-1:0]    req_wdata,
    input  logic                          sel_row,
    input  logic                          sel_col,
    input  logic                          wr_drive,
    input  logic                          sample,
    input  logic [LANES*LANE_BITS-1:0]    mem_dq_in,
    output logic [LANES-1:0]              lat_be,
    output logic                          lat_wr,
    output logic [ROW_BITS-1:0]           mem_addr,
    output logic [LANES*LANE_BITS-1:0]    mem_dq_out,
    output logic [LANES-1:0]              mem_dq_oe,
    output logic                          rsp_valid,
    output logic [LANES*LANE_BITS-1:0]    rsp_rdata
);

    localparam int AW = ROW_BITS + COL_BITS;
    localparam int DW = LANES * LANE_BITS;

    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [DW-1:0] rd_masked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_be    <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_be    <= req_be;
            lat_wr    <= req_write;
            lat_wdata <= req_wdata;
        end
    end

    always_comb begin
        if (sel_row) begin
            mem_addr = lat_addr[AW-1:COL_BITS];
        end else if (sel_col) begin
            mem_addr = ROW_BITS'(lat_addr[COL_BITS-1:0]);
        end else begin
            mem_addr = '0;
        end
    end

    assign mem_dq_out = lat_wdata;
    assign mem_dq_oe  = wr_drive ? lat_be : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_masked[g*LANE_BITS +: LANE_BITS] =
            lat_be[g] ? mem_dq_in[g*LANE_BITS +: LANE_BITS] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) begin
                rsp_rdata <= rd_masked;
            end
        end
    end

    // R7: the response lasts one cycle, since a single sample ends its column phase
    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: a driven lane is always one the request selected
    a_r5_drive_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_dq_oe & ~lat_be) == '0));

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
    parameter int ROW_BITS  = 10,
    parameter int COL_BITS  = 10,
    parameter int LANES     = 2,
    parameter int LANE_BITS = 8,
    parameter int CLK_KHZ   = 100000,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 2,
    parameter int T_CSR     = 1,
    parameter int T_REF     = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_write,
    input  logic [ROW_BITS+COL_BITS-1:0]     req_addr,
    input  logic [LANES-1:0]                 req_be,
    input  logic [LANES*LANE_BITS-1:0]       req_wdata,
    output logic                             rsp_valid,
    output logic [LANES*LANE_BITS-1:0]       rsp_rdata,
    output logic [ROW_BITS-1:0]              mem_addr,
    output logic                             mem_ras_n,
    output logic [LANES-1:0]                 mem_cas_n,
    output logic                             mem_we_n,
    output logic                             mem_oe_n,
    output logic [LANES*LANE_BITS-1:0]       mem_dq_out,
    output logic [LANES-1:0]                 mem_dq_oe,
    input  logic [LANES*LANE_BITS-1:0]       mem_dq_in
);

    // 1024 refreshes in 16 ms: one every 15.6 us
    localparam int REF_TICKS = CLK_KHZ * 156 / 10000;

    logic             ref_pend;
    logic             ref_ack;
    logic             accept;
    logic             sel_row;
    logic             sel_col;
    logic             wr_drive;
    logic             sample;
    logic [LANES-1:0] lat_be;
    logic             lat_wr;

    edo_refresh_pacer #(
        .REF_TICKS (REF_TICKS)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    edo_seq_fsm #(
        .LANES (LANES),
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RP  (T_RP),
        .T_CSR (T_CSR),
        .T_REF (T_REF)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ref_pend  (ref_pend),
        .lat_be    (lat_be),
        .lat_wr    (lat_wr),
        .req_ready (req_ready),
        .accept    (accept),
        .ref_ack   (ref_ack),
        .sel_row   (sel_row),
        .sel_col   (sel_col),
        .wr_drive  (wr_drive),
        .sample    (sample),
        .ras_n     (mem_ras_n),
        .cas_n     (mem_cas_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n)
    );

    edo_datapath #(
        .ROW_BITS  (ROW_BITS),
        .COL_BITS  (COL_BITS),
        .LANES     (LANES),
        .LANE_BITS (LANE_BITS)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .sel_row    (sel_row),
        .sel_col    (sel_col),
        .wr_drive   (wr_drive),
        .sample     (sample),
        .mem_dq_in  (mem_dq_in),
        .lat_be     (lat_be),
        .lat_wr     (lat_wr),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    // R11: standby means no output enable and no lane driven
    a_r11_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ras_n |-> (mem_oe_n && (mem_dq_oe == '0)));

    // R4: after the row strobe rises it stays high for the next cycle too
    if (T_RP > 1) begin : g_prechg_chk
        a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mem_ras_n) |=> mem_ras_n);
    end

endmodule

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ROWB  = 10;
    localparam int COLB  = 10;
    localparam int LN    = 2;
    localparam int LB    = 8;
    localparam int DW    = LN * LB;
    localparam int KHZ   = 5000;
    localparam int TRCD  = 2;
    localparam int TCAS  = 2;
    localparam int TRP   = 2;
    localparam int TCSR  = 1;
    localparam int TREF  = 3;
    localparam int RTICK = KHZ * 156 / 10000;
    localparam int SLACK = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [19:0]     req_addr = '0;
    logic [1:0]      req_be = '0;
    logic [15:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [15:0]     rsp_rdata;
    logic [9:0]      mem_addr;
    logic            mem_ras_n;
    logic [1:0]      mem_cas_n;
    logic            mem_we_n;
    logic            mem_oe_n;
    logic [15:0]     mem_dq_out;
    logic [1:0]      mem_dq_oe;
    logic [15:0]     mem_dq_in;

    edo_dram_ctrl #(
        .ROW_BITS (ROWB), .COL_BITS (COLB), .LANES (LN), .LANE_BITS (LB),
        .CLK_KHZ (KHZ), .T_RCD (TRCD), .T_CAS (TCAS), .T_RP (TRP),
        .T_CSR (TCSR), .T_REF (TREF)
    ) i_edo_dram_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_ras_n (mem_ras_n), .mem_cas_n (mem_cas_n),
        .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out),
        .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] model_mem [0:4095];
    logic [9:0]  m_row = '0;
    logic        m_pras = 1'b1;
    logic [1:0]  m_pcas = 2'b11;

    function automatic int midx(input logic [9:0] r, input logic [9:0] c);
        return int'({r[5:0], c[5:0]});
    endfunction

    always @(negedge clk) begin
        if (m_pras && !mem_ras_n && mem_cas_n == 2'b11) m_row <= mem_addr;
        for (int i = 0; i < LN; i++) begin
            if (!mem_ras_n && m_pcas[i] && !mem_cas_n[i] && !mem_we_n)
                model_mem[midx(m_row, mem_addr)][i*LB +: LB] <= mem_dq_out[i*LB +: LB];
        end
        m_pras <= mem_ras_n;
        m_pcas <= mem_cas_n;
    end

    always_comb begin
        for (int i = 0; i < LN; i++) begin
            if (!mem_ras_n && !mem_cas_n[i] && !mem_oe_n)
                mem_dq_in[i*LB +: LB] = model_mem[midx(m_row, mem_addr)][i*LB +: LB];
            else
                mem_dq_in[i*LB +: LB] = 8'hEE;
        end
    end

    // ---------------- driver / scoreboard ----------------
    typedef struct packed {
        logic [19:0] a;
        logic [1:0]  be;
        logic        wr;
        logic [15:0] d;
    } acc_t;

    acc_t        acc_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] shadow [0:4095];

    function automatic logic [19:0] mk(input int r, input int c);
        return {10'(r), 10'(c)};
    endfunction

    task automatic issue(input logic wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
        acc_t t;
        logic [15:0] e;
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        t.a = a; t.be = be; t.wr = wr; t.d = d;
        acc_q.push_back(t);
        k = midx(a[19:10], a[9:0]);
        e = '0;
        for (int i = 0; i < LN; i++) begin
            if (be[i]) begin
                if (wr) shadow[k][i*LB +: LB] = d[i*LB +: LB];
                else    e[i*LB +: LB] = shadow[k][i*LB +: LB];
            end
        end
        if (!wr) exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    bit   mon_on = 1'b0;
    logic p_ras = 1'b1;
    bit   p_any = 1'b0;
    bit   in_acc = 1'b0;
    acc_t cur = '0;
    int   ras_low_cnt = 0, cas_low_cnt = 0, ras_high_cnt = 100, cas_pre_cnt = 0, ref_low_cnt = 0;
    int   cyc = 0, last_ref = -1, ref_count = 0;

    always @(negedge clk) begin
        bit any;
        logic [15:0] got;
        if (mon_on) begin
            cyc++;
            any = (mem_cas_n != 2'b11);
            if (p_ras && !mem_ras_n) begin
                chk(ras_high_cnt >= TRP, "R4 precharge width", ras_high_cnt, TRP);
                if (!any) begin
                    in_acc = 1'b1;
                    if (acc_q.size() == 0) begin
                        chk(1'b0, "R2 access without accepted request", 0, 1);
                        cur = '0;
                    end else cur = acc_q.pop_front();
                    chk(mem_addr == cur.a[19:10], "R3 row address", mem_addr, cur.a[19:10]);
                    chk(mem_we_n == !cur.wr, "R6 write enable at row fall", mem_we_n, !cur.wr);
                    ras_low_cnt = 1;
                end else begin
                    in_acc = 1'b0;
                    ref_count++;
                    ref_low_cnt = 1;
                    chk(cas_pre_cnt >= TCSR, "R9 CAS lead before RAS", cas_pre_cnt, TCSR);
                    chk(mem_cas_n == 2'b00 && mem_oe_n && mem_dq_oe == 0, "R9 refresh strobes",
                        {mem_cas_n, mem_oe_n, mem_dq_oe}, 5'b00100);
                    if (last_ref >= 0)
                        chk((cyc - last_ref) >= RTICK - SLACK && (cyc - last_ref) <= RTICK + SLACK,
                            "R8/R10 refresh spacing", cyc - last_ref, RTICK);
                    last_ref = cyc;
                end
            end else if (!mem_ras_n && in_acc) begin
                if (!p_any && any) begin
                    chk(ras_low_cnt == TRCD, "R4 RAS-to-CAS cycles", ras_low_cnt, TRCD);
                    chk(~mem_cas_n == cur.be, "R5 lane strobes", ~mem_cas_n, cur.be);
                    chk(mem_addr == cur.a[9:0], "R3 column address", mem_addr, cur.a[9:0]);
                    if (cur.wr) begin
                        chk(!mem_we_n && mem_oe_n && mem_dq_oe == cur.be, "R6 write strobes",
                            {mem_we_n, mem_oe_n, mem_dq_oe}, {2'b01, cur.be});
                        for (int i = 0; i < LN; i++)
                            if (cur.be[i])
                                chk(mem_dq_out[i*LB +: LB] == cur.d[i*LB +: LB], "R6 write data lane",
                                    mem_dq_out[i*LB +: LB], cur.d[i*LB +: LB]);
                    end else begin
                        chk(mem_we_n && !mem_oe_n && mem_dq_oe == 0, "R7 read strobes",
                            {mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1000);
                    end
                    cas_low_cnt = 1;
                end else if (any) cas_low_cnt++;
                else ras_low_cnt++;
            end else if (!mem_ras_n && !in_acc) begin
                ref_low_cnt++;
            end
            if (!p_ras && mem_ras_n) begin
                chk(!any, "R4/R9 strobes rise together", mem_cas_n, 2'b11);
                if (in_acc) chk(cas_low_cnt == TCAS, "R4 CAS width", cas_low_cnt, TCAS);
                else        chk(ref_low_cnt == TREF, "R9 refresh RAS width", ref_low_cnt, TREF);
            end
            if (mem_ras_n) begin
                ras_high_cnt = p_ras ? ras_high_cnt + 1 : 1;
                cas_pre_cnt  = any ? cas_pre_cnt + 1 : 0;
                chk(mem_oe_n && mem_dq_oe == 0, "R11 standby quiet", {mem_oe_n, mem_dq_oe}, 3'b100);
            end else begin
                chk(!req_ready, "R2 ready low during access", req_ready, 0);
            end
            if (rsp_valid) begin
                chk(p_any && !any, "R7 response timing", {p_any, any}, 2'b10);
                if (exp_q.size() == 0) chk(1'b0, "R7 unexpected response", rsp_rdata, 0);
                else begin
                    got = exp_q.pop_front();
                    chk(rsp_rdata == got, "R7/R5 read data", rsp_rdata, got);
                end
            end
            p_ras = mem_ras_n;
            p_any = any;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 4096; i++) begin
            model_mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(mem_ras_n && mem_cas_n == 2'b11 && mem_we_n && mem_oe_n && mem_dq_oe == 0 && !rsp_valid,
            "R1 outputs in reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid},
            8'b11111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && mem_ras_n && mem_cas_n == 2'b11, "R1 state after reset",
            {req_ready, rsp_valid, mem_ras_n, mem_cas_n}, 5'b10111);
        mon_on = 1'b1;

        // word writes and byte merges
        issue(1'b1, mk(3, 5), 2'b11, 16'hA55A);
        issue(1'b1, mk(3, 6), 2'b11, 16'h1234);
        issue(1'b1, mk(7, 1), 2'b11, 16'hBEEF);
        issue(1'b1, mk(3, 5), 2'b01, 16'h99CD);
        issue(1'b1, mk(7, 1), 2'b10, 16'h7711);
        idle(3);
        issue(1'b0, mk(3, 5), 2'b11, 16'h0);
        issue(1'b0, mk(7, 1), 2'b11, 16'h0);
        issue(1'b0, mk(3, 6), 2'b01, 16'h0);
        issue(1'b0, mk(3, 6), 2'b10, 16'h0);
        issue(1'b0, mk(0, 0), 2'b11, 16'h0);
        idle(RTICK);

        // back-to-back stream: refresh must still be taken (R10)
        for (int i = 0; i < 40; i++)
            issue(1'b1, mk(10 + i % 8, i % 16 + 20), (i % 3 == 0) ? 2'b01 : 2'b11,
                  16'(i * 257 + 7));
        for (int i = 0; i < 40; i++)
            issue(1'b0, mk(10 + i % 8, i % 16 + 20), (i % 2 == 0) ? 2'b11 : 2'b10, 16'h0);
        idle(3 * RTICK);

        chk(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
        chk(acc_q.size() == 0, "R2 all requests executed", acc_q.size(), 0);
        chk(ref_count >= cyc / RTICK - 1, "R8 refresh count", ref_count, cyc / RTICK - 1);
        summary();
    end

endmodule